// File: doc/BRIEF.md
# Posit Encoder with Rounding

This block packs a number held as sign, signed base-2 scale and fraction (value `(-1)^sign * 2^scale * 1.frac`) into an N-bit posit with ES exponent bits. The input can come from a posit decoder, a multiply-accumulate datapath or a float converter. Separate flags mark the special cases zero and infinity. Finite magnitudes outside the representable span are not sent to the infinity code. They saturate to the largest or the smallest posit.

The scale splits into a regime value (scale shifted right arithmetically by ES, which is a floor) and a local exponent (the low ES bits of the scale). A seeded working vector holds the regime pattern, the exponent and the fraction. Two shifters, one for non-negative and one for negative regimes, place the regime, so no adder sits on either shift amount. The dropped bits feed a round-to-nearest-even step. A negative result is the two's complement of the rounded positive word. An optional output register with a valid flag follows the combinational path.

Top module: `posit_encoder`

## Requirements
- R1: When `in_zero` is set and `in_inf` is clear, the output word is all zeros, whatever the other inputs are.
- R2: When `in_inf` is set, the output word is a one in the MSB followed by zeros (0x80 for N=8). This takes priority over `in_zero`.
- R3: A finite input whose scale is at least (N-2)*2^ES gives maxpos (0x7F for N=8, ES=1), or its negation (0x81) when the sign is set.
- R4: A finite input whose scale is below -(N-2)*2^ES gives minpos (0x01), or its negation (0xFF) when the sign is set.
- R5: In range, the regime value is floor(scale / 2^ES) and the exponent field holds the remainder. The posit body reads, from the MSB down: a zero sign bit, then k+1 ones and a zero for k>=0 or -k zeros and a one for k<0, then ES exponent bits, then the fraction MSB first. For N=8, ES=1: 1.0 gives 0x40, 2.0 gives 0x50, 0.5 gives 0x30 and 1.5 gives 0x48.
- R6: Bits that do not fit are rounded to nearest with ties to even. The guard bit is the first dropped bit, and the sticky bit is the OR of all bits after it. For example, scale 0 with fraction 0x08 gives 0x40, 0x18 gives 0x42 and 0x09 gives 0x41.
- R7: A finite non-zero input never gives 0 or the infinity code. If rounding would carry past maxpos, the result stays at maxpos (scale 11 with fraction 0xFF gives 0x7F).
- R8: A negative input gives the two's complement of the word that the same magnitude gives when positive (-1.0 gives 0xC0, -1.5 gives 0xB8).
- R9: With the output register enabled, `out_valid` equals the previous cycle's `in_valid`. `out_posit` loads only on cycles where `in_valid` is high and otherwise holds its value.
- R10: While `rst_n` is low, `out_valid` and `out_posit` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_sign | input | 1 | Sign of the value, 1 = negative |
| in_scale | input | SW | Signed base-2 scale of the value |
| in_frac | input | FW | Fraction bits below the hidden one, MSB first |
| in_zero | input | 1 | Value is zero |
| in_inf | input | 1 | Value is infinity |
| out_valid | output | 1 | Output word is valid |
| out_posit | output | N | Encoded posit |

## Verification
The checker assumes that the output register is enabled. It also assumes that inputs change only between clock edges, so each registered output is tied to the flags and sign sampled one edge earlier. The bench follows these assumptions by driving every input on the falling edge. It keeps `in_valid` low through reset and sets at most the flags a vector calls for, with the scale always held within the SW-bit signed range. A behavioural reference builds the posit as a bit queue with explicit floor division. It runs over a sweep of scales beyond both saturation limits, with several fractions and both signs, next to hand-worked values and rounding ties.

// File: rtl/posit_enc_pkg.sv
`timescale 1ns/1ps
package posit_enc_pkg;
  // Saturation class of a finite input after the range test.
  typedef enum logic [1:0] {
    SAT_NONE = 2'd0,
    SAT_HI   = 2'd1,
    SAT_LO   = 2'd2
  } sat_e;
endpackage

// File: rtl/posit_scale_clip.sv
`timescale 1ns/1ps
module posit_scale_clip
  import posit_enc_pkg::*;
#(
  parameter int N  = 8,
  parameter int ES = 1,
  parameter int SW = 8
) (
  input  logic signed [SW-1:0]           scale_i,
  output sat_e                           sat_o,
  output logic signed [SW-1:0]           k_o,
  output logic [((ES > 0) ? ES : 1)-1:0] e_o
);
  localparam int EW   = (ES > 0) ? ES : 1;
  localparam int MAXS = (N - 2) * (1 << ES);
  localparam int MINS = -MAXS;

  always_comb begin
    k_o = scale_i >>> ES;          // floor(scale / 2^ES)
    e_o = '0;
    if (ES > 0) e_o = scale_i[EW-1:0];
    if (int'(scale_i) >= MAXS)     sat_o = SAT_HI;
    else if (int'(scale_i) < MINS) sat_o = SAT_LO;
    else                           sat_o = SAT_NONE;
  end
endmodule

// File: rtl/posit_regime_shift.sv
`timescale 1ns/1ps
module posit_regime_shift #(
  parameter int N  = 8,
  parameter int ES = 1,
  parameter int FW = 8,
  parameter int SW = 8
) (
  input  logic signed [SW-1:0]           k_i,
  input  logic [((ES > 0) ? ES : 1)-1:0] e_i,
  input  logic [FW-1:0]                  frac_i,
  output logic [N-2:0]                   body_o,
  output logic                           guard_o,
  output logic                           sticky_o
);
  localparam int EW  = (ES > 0) ? ES : 1;
  localparam int TW  = ES + FW;
  localparam int PAD = 2 * N;
  localparam int WW  = 2 + TW + PAD;
  localparam int SAW = $clog2(WW);

  logic [TW-1:0]        tail;
  logic [WW-1:0]        pos_seed, neg_seed, pos_sh, neg_sh, pick;
  logic [SAW-1:0]       pos_amt, neg_amt;
  logic signed [SW-1:0] k_inv;

  generate
    if (ES > 0) begin : g_exp
      assign tail = {e_i[EW-1:0], frac_i};
    end else begin : g_noexp
      logic unused_e;
      assign unused_e = e_i[0];
      assign tail     = frac_i;
    end
  endgenerate

  // Seeds carry the first regime bits so each shift is k or ~k, no adder.
  assign pos_seed = {2'b10, tail, {PAD{1'b0}}};
  assign neg_seed = {2'b01, tail, {PAD{1'b0}}};
  assign k_inv    = ~k_i;
  assign pos_amt  = k_i[SAW-1:0];
  assign neg_amt  = k_inv[SAW-1:0];

  always_comb begin
    pos_sh   = $signed(pos_seed) >>> pos_amt;   // ones fill: k+1 ones
    neg_sh   = neg_seed >> neg_amt;             // zeros fill: -k zeros
    pick     = k_i[SW-1] ? neg_sh : pos_sh;
    body_o   = pick[WW-1 -: N-1];
    guard_o  = pick[WW-N];
    sticky_o = |pick[WW-N-1:0];
  end
endmodule

// File: rtl/posit_round_pack.sv
`timescale 1ns/1ps
module posit_round_pack
  import posit_enc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         sign_i,
  input  logic         zero_i,
  input  logic         inf_i,
  input  sat_e         sat_i,
  input  logic [N-2:0] body_i,
  input  logic         guard_i,
  input  logic         sticky_i,
  output logic [N-1:0] word_o
);
  localparam logic [N-2:0] MAG_MIN = {{(N-2){1'b0}}, 1'b1};
  localparam logic [N-2:0] MAG_MAX = '1;

  logic         up;
  logic [N-2:0] mag;
  logic [N-1:0] pos_word;

  always_comb begin
    up  = guard_i & (sticky_i | body_i[0]);
    mag = body_i;
    if (up && (body_i != MAG_MAX)) mag = body_i + 1'b1;
    if (mag == '0) mag = MAG_MIN;
    case (sat_i)
      SAT_HI:  mag = MAG_MAX;
      SAT_LO:  mag = MAG_MIN;
      default: ;
    endcase
    pos_word = {1'b0, mag};
    word_o   = sign_i ? (~pos_word + 1'b1) : pos_word;
    if (inf_i)       word_o = {1'b1, {(N-1){1'b0}}};
    else if (zero_i) word_o = '0;
  end
endmodule

// File: rtl/posit_encoder.sv
`timescale 1ns/1ps
module posit_encoder
  import posit_enc_pkg::*;
#(
  parameter int N       = 8,
  parameter int ES      = 1,
  parameter int FW      = 8,
  parameter int SW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sign,
  input  logic [SW-1:0] in_scale,
  input  logic [FW-1:0] in_frac,
  input  logic          in_zero,
  input  logic          in_inf,
  output logic          out_valid,
  output logic [N-1:0]  out_posit
);
  localparam int EW = (ES > 0) ? ES : 1;

  sat_e                 sat;
  logic signed [SW-1:0] k;
  logic [EW-1:0]        e;
  logic [N-2:0]         body;
  logic                 guard, sticky;
  logic [N-1:0]         word;

  posit_scale_clip #(.N(N), .ES(ES), .SW(SW)) clip_i (
    .scale_i (in_scale),
    .sat_o   (sat),
    .k_o     (k),
    .e_o     (e)
  );

  posit_regime_shift #(.N(N), .ES(ES), .FW(FW), .SW(SW)) shift_i (
    .k_i      (k),
    .e_i      (e),
    .frac_i   (in_frac),
    .body_o   (body),
    .guard_o  (guard),
    .sticky_o (sticky)
  );

  posit_round_pack #(.N(N)) pack_i (
    .sign_i   (in_sign),
    .zero_i   (in_zero),
    .inf_i    (in_inf),
    .sat_i    (sat),
    .body_i   (body),
    .guard_i  (guard),
    .sticky_i (sticky),
    .word_o   (word)
  );

  generate
    if (OUT_REG) begin : g_reg
      logic         vld_d, vld_q;
      logic [N-1:0] pos_d, pos_q;

      always_comb begin
        vld_d = in_valid;
        pos_d = pos_q;
        if (in_valid) pos_d = word;   // clock enable
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          pos_q <= '0;
        end else begin
          vld_q <= vld_d;
          pos_q <= pos_d;
        end
      end

      assign out_valid = vld_q;
      assign out_posit = pos_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign out_valid  = in_valid;
      assign out_posit  = word;
    end
  endgenerate
endmodule

// File: rtl/posit_encoder_chk.sv
`timescale 1ns/1ps
module posit_encoder_chk #(
  parameter int N       = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_sign,
  input logic         in_zero,
  input logic         in_inf,
  input logic         out_valid,
  input logic [N-1:0] out_posit
);
  localparam logic [N-1:0] INF_CODE = {1'b1, {(N-1){1'b0}}};

  generate
    if (OUT_REG) begin : g_props
      // R1
      zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_zero && !in_inf) |=> (out_posit == '0));
      // R2
      inf_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_inf) |=> (out_posit == INF_CODE));
      // R7
      no_collapse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_zero && !in_inf) |=>
          (out_posit != '0 && out_posit != INF_CODE));
      // R8
      sign_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_zero && !in_inf) |=> (out_posit[N-1] == $past(in_sign)));
      // R9
      valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      // R9
      valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
      // R9
      hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_posit));
    end
  endgenerate
endmodule

bind posit_encoder posit_encoder_chk #(.N(N), .OUT_REG(OUT_REG)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_sign   (in_sign),
  .in_zero   (in_zero),
  .in_inf    (in_inf),
  .out_valid (out_valid),
  .out_posit (out_posit)
);

// File: tb/posit_encoder_tb.sv
`timescale 1ns/1ps
module posit_encoder_tb_top;
  localparam int N  = 8;
  localparam int ES = 1;
  localparam int FW = 8;
  localparam int SW = 8;

  logic          clk;
  logic          rst_n;
  logic          in_valid, in_sign, in_zero, in_inf;
  logic [SW-1:0] in_scale;
  logic [FW-1:0] in_frac;
  logic          out_valid;
  logic [N-1:0]  out_posit;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  posit_encoder #(.N(N), .ES(ES), .FW(FW), .SW(SW), .OUT_REG(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_scale(in_scale), .in_frac(in_frac), .in_zero(in_zero),
    .in_inf(in_inf), .out_valid(out_valid), .out_posit(out_posit)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference: builds the posit as a queue of bits.
  function automatic logic [N-1:0] ref_enc(input logic s, input int sc,
                                           input logic [FW-1:0] f,
                                           input logic z, input logic inf);
    bit q[$];
    int k, e, m, lim, useed_log;
    bit g, st;
    useed_log = 1 << ES;
    lim = (N - 2) * useed_log;
    if (inf) return {1'b1, {(N-1){1'b0}}};
    if (z) return '0;
    if (sc >= lim) m = (1 << (N - 1)) - 1;
    else if (sc < -lim) m = 1;
    else begin
      k = (sc >= 0) ? sc / useed_log : -((-sc + useed_log - 1) / useed_log);
      e = sc - k * useed_log;
      if (k >= 0) begin
        repeat (k + 1) q.push_back(1'b1);
        q.push_back(1'b0);
      end else begin
        repeat (-k) q.push_back(1'b0);
        q.push_back(1'b1);
      end
      for (int i = ES - 1; i >= 0; i--) q.push_back(((e >> i) & 1) != 0);
      for (int i = FW - 1; i >= 0; i--) q.push_back(f[i]);
      while (q.size() < N + 1) q.push_back(1'b0);
      m = 0;
      for (int i = 0; i < N - 1; i++) m = m * 2 + int'(q[i]);
      g  = q[N-1];
      st = 1'b0;
      for (int i = N; i < q.size(); i++) st |= q[i];
      if (g && (st || (m % 2 == 1)) && m != (1 << (N - 1)) - 1) m++;
      if (m == 0) m = 1;
    end
    if (s) m = (1 << N) - m;
    return m[N-1:0];
  endfunction

  task automatic check(input string req, input logic [N-1:0] got,
                       input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive on a falling edge, sample one full cycle later.
  task automatic apply(input string req, input logic s, input int sc,
                       input logic [FW-1:0] f, input logic z, input logic inf,
                       input logic [N-1:0] exp);
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_scale = sc[SW-1:0];
    in_frac = f; in_zero = z; in_inf = inf;
    @(negedge clk);
    check({req, " valid"}, {{(N-1){1'b0}}, out_valid}, {{(N-1){1'b0}}, 1'b1});
    check(req, out_posit, exp);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_sign = 1'b0; in_scale = '0;
    in_frac = '0; in_zero = 1'b0; in_inf = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset valid", {{(N-1){1'b0}}, out_valid}, '0);
    check("R10 reset word", out_posit, '0);
    rst_n = 1'b1;

    apply("R1 zero",          1'b1,  5, 8'hA5, 1'b1, 1'b0, 8'h00);
    apply("R2 inf",           1'b0,  0, 8'h00, 1'b0, 1'b1, 8'h80);
    apply("R2 inf over zero", 1'b1,  3, 8'h11, 1'b1, 1'b1, 8'h80);
    apply("R5 one",           1'b0,  0, 8'h00, 1'b0, 1'b0, 8'h40);
    apply("R5 two",           1'b0,  1, 8'h00, 1'b0, 1'b0, 8'h50);
    apply("R5 half",          1'b0, -1, 8'h00, 1'b0, 1'b0, 8'h30);
    apply("R5 one and half",  1'b0,  0, 8'h80, 1'b0, 1'b0, 8'h48);
    apply("R8 minus one",     1'b1,  0, 8'h00, 1'b0, 1'b0, 8'hC0);
    apply("R8 minus 1.5",     1'b1,  0, 8'h80, 1'b0, 1'b0, 8'hB8);
    apply("R6 tie to even",   1'b0,  0, 8'h08, 1'b0, 1'b0, 8'h40);
    apply("R6 tie to odd up", 1'b0,  0, 8'h18, 1'b0, 1'b0, 8'h42);
    apply("R6 above tie",     1'b0,  0, 8'h09, 1'b0, 1'b0, 8'h41);
    apply("R3 at limit",      1'b0, 12, 8'h00, 1'b0, 1'b0, 8'h7F);
    apply("R3 far above",     1'b0, 40, 8'h3C, 1'b0, 1'b0, 8'h7F);
    apply("R3 negative",      1'b1, 40, 8'h3C, 1'b0, 1'b0, 8'h81);
    apply("R4 below limit",   1'b0,-13, 8'hFF, 1'b0, 1'b0, 8'h01);
    apply("R4 negative",      1'b1,-60, 8'h00, 1'b0, 1'b0, 8'hFF);
    apply("R4 at lower edge", 1'b0,-12, 8'h00, 1'b0, 1'b0, 8'h01);
    apply("R7 no carry to inf", 1'b0, 11, 8'hFF, 1'b0, 1'b0, 8'h7F);

    // R9: in_valid low holds the word and drops out_valid.
    apply("R9 load", 1'b0, 0, 8'h00, 1'b0, 1'b0, 8'h40);
    @(negedge clk);
    in_valid = 1'b0; in_sign = 1'b1; in_scale = 8'd7; in_frac = 8'h55;
    @(negedge clk);
    check("R9 valid low", {{(N-1){1'b0}}, out_valid}, '0);
    check("R9 hold", out_posit, 8'h40);

    // R5 R6 R8 sweep against the reference.
    for (int sc = -16; sc <= 16; sc++) begin
      for (int j = 0; j < 4; j++) begin
        for (int sg = 0; sg < 2; sg++) begin
          logic [FW-1:0] f;
          f = FW'(((sc + 16) * 29 + j * 71 + 5) % 256);
          apply("R5 sweep", sg[0], sc, f, 1'b0, 1'b0,
                ref_enc(sg[0], sc, f, 1'b0, 1'b0));
        end
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule